// File: doc/BRIEF.md
# PWM Duty and Period Update Lockout

This block sits between the registers that software writes and the active registers that a PWM generator compares against. It holds three duty-cycle buffers and one period buffer, each with its own write port. It copies every buffer to its active register on the period-boundary strobe that the PWM counter supplies. The counter and the comparators are outside this block.

A single lockout input freezes every transfer, duty and period alike. Software can then rewrite several buffers and release them together. An immediate-update input lets a duty write reach its active register on the same clock edge, whatever the lockout and the boundary are doing. That input has no effect on the period, which always waits for a boundary with the lockout clear. A buffer written on the same edge as a transfer passes the new value straight to the active register.

Top module: `pwm_update_lockout`

## Requirements
- R1: On reset, all buffer and active registers are zero. A transfer after reset with no intervening write loads zeros.
- R2: While lockout is 1, no active register changes, even on a boundary strobe. The only exception is a duty write with immediate-update set (R4).
- R3: With lockout 0, a boundary strobe loads all three active duties and the active period from their buffers on the same clock edge.
- R4: A duty write with immediate-update 1 sets that channel's active duty to the written value on the write's clock edge. This holds for any lockout or boundary state. The written value also becomes the channel's buffered value.
- R5: Immediate-update has no effect on the period. A period write made with immediate-update 1 leaves the active period unchanged until a boundary strobe with lockout 0.
- R6: With no boundary strobe, a buffer write without immediate-update leaves every active register unchanged. The value is held in its buffer.
- R7: Clearing lockout does not itself load anything. Buffer values written during the lockout load at the next boundary strobe that has lockout 0.
- R8: A buffer write on the same clock edge as a transfer makes the active register take the newly written value.
- R9: Each channel's buffer changes only through its own write port. A later transfer loads an untouched channel's earlier value, including a value written with immediate-update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dutyWrEn | input | NUM_DUTY | Per-channel duty buffer write strobe; bit i selects channel i |
| dutyWrData | input | NUM_DUTY x DUTY_W | Duty write data; element i goes to channel i |
| perWrEn | input | 1 | Period buffer write strobe |
| perWrData | input | PER_W | Period write data |
| lockout | input | 1 | 1 blocks every buffer-to-active transfer |
| immUpdate | input | 1 | 1 makes duty writes take effect on the write edge |
| boundary | input | 1 | One-cycle period-boundary strobe from the PWM counter |
| dutyActive | output | NUM_DUTY x DUTY_W | Active duty values |
| perActive | output | PER_W | Active period value |

## Verification
Two events can fall on the same edge: a buffer write and a boundary transfer. Both the normal write path and the immediate path can meet a boundary, with the lockout either set or clear. The vector table raises write strobes and the boundary strobe in one cycle. It expects the fresh write value in the active register when the transfer is allowed. It also combines immediate-update with lockout and a boundary, and expects the duty to change while the period holds. Every check samples on the falling edge after the rising edge that carries the stimulus. Expected values come from the table alone.

// File: rtl/pwm_ul_pkg.sv
package pwm_ul_pkg;

  // Strobes from control to datapath, all valid for one clock.
  typedef struct packed {
    logic xferDuty;    // copy duty buffers to active at this edge
    logic xferPer;     // copy period buffer to active at this edge
    logic bypassDuty;  // duty writes go straight to active at this edge
  } ul_strobe_t;

endpackage

// File: rtl/pwm_ul_ctrl.sv
module pwm_ul_ctrl
  import pwm_ul_pkg::*;
(
  input  logic       lockout,
  input  logic       immUpdate,
  input  logic       boundary,
  output ul_strobe_t strobes
);

  logic xferOk;

  always_comb begin
    xferOk             = boundary & ~lockout;
    strobes.xferDuty   = xferOk;
    strobes.xferPer    = xferOk;
    strobes.bypassDuty = immUpdate;
  end

endmodule

// File: rtl/pwm_ul_slot.sv
module pwm_ul_slot #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic [W-1:0] wrData,
  input  logic         xfer,
  input  logic         bypass,
  output logic [W-1:0] active
);

  logic [W-1:0] bufQ;
  logic [W-1:0] bufNext;
  logic [W-1:0] activeQ;
  logic         loadActive;

  always_comb begin
    bufNext    = wrEn ? wrData : bufQ;
    loadActive = xfer | (bypass & wrEn);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufQ    <= '0;
      activeQ <= '0;
    end else begin
      if (wrEn)       bufQ    <= wrData;
      if (loadActive) activeQ <= bufNext;
    end
  end

  assign active = activeQ;

endmodule

// File: rtl/pwm_ul_datapath.sv
module pwm_ul_datapath
  import pwm_ul_pkg::*;
#(
  parameter int unsigned NUM_DUTY = 3,
  parameter int unsigned DUTY_W   = 16,
  parameter int unsigned PER_W    = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ul_strobe_t                     strobes,
  input  logic [NUM_DUTY-1:0]            dutyWrEn,
  input  logic [NUM_DUTY-1:0][DUTY_W-1:0] dutyWrData,
  input  logic                           perWrEn,
  input  logic [PER_W-1:0]               perWrData,
  output logic [NUM_DUTY-1:0][DUTY_W-1:0] dutyActive,
  output logic [PER_W-1:0]               perActive
);

  for (genvar ch = 0; ch < NUM_DUTY; ch++) begin : g_duty
    pwm_ul_slot #(.W(DUTY_W)) u_slot (
      .clk    (clk),
      .rstN   (rstN),
      .wrEn   (dutyWrEn[ch]),
      .wrData (dutyWrData[ch]),
      .xfer   (strobes.xferDuty),
      .bypass (strobes.bypassDuty),
      .active (dutyActive[ch])
    );
  end

  // The period never takes the bypass path.
  pwm_ul_slot #(.W(PER_W)) u_perSlot (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (perWrEn),
    .wrData (perWrData),
    .xfer   (strobes.xferPer),
    .bypass (1'b0),
    .active (perActive)
  );

endmodule

// File: rtl/pwm_update_lockout.sv
module pwm_update_lockout
  import pwm_ul_pkg::*;
#(
  parameter int unsigned NUM_DUTY = 3,
  parameter int unsigned DUTY_W   = 16,
  parameter int unsigned PER_W    = 16
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [NUM_DUTY-1:0]             dutyWrEn,
  input  logic [NUM_DUTY-1:0][DUTY_W-1:0] dutyWrData,
  input  logic                            perWrEn,
  input  logic [PER_W-1:0]                perWrData,
  input  logic                            lockout,
  input  logic                            immUpdate,
  input  logic                            boundary,
  output logic [NUM_DUTY-1:0][DUTY_W-1:0] dutyActive,
  output logic [PER_W-1:0]                perActive
);

  ul_strobe_t strobes;

  pwm_ul_ctrl u_ctrl (
    .lockout   (lockout),
    .immUpdate (immUpdate),
    .boundary  (boundary),
    .strobes   (strobes)
  );

  pwm_ul_datapath #(
    .NUM_DUTY (NUM_DUTY),
    .DUTY_W   (DUTY_W),
    .PER_W    (PER_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .dutyWrEn   (dutyWrEn),
    .dutyWrData (dutyWrData),
    .perWrEn    (perWrEn),
    .perWrData  (perWrData),
    .dutyActive (dutyActive),
    .perActive  (perActive)
  );

  AST_LOCK_FREEZE_DUTY: assert property (@(posedge clk) disable iff (!rstN)
    (lockout && !immUpdate) |=> $stable(dutyActive)); // R2
  AST_LOCK_FREEZE_PER: assert property (@(posedge clk) disable iff (!rstN)
    lockout |=> $stable(perActive)); // R2
  AST_PER_WAITS_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    !boundary |=> $stable(perActive)); // R5
  AST_DUTY_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!boundary && !(immUpdate && (|dutyWrEn))) |=> $stable(dutyActive)); // R6
  AST_SAME_EDGE_PER: assert property (@(posedge clk) disable iff (!rstN)
    (boundary && !lockout && perWrEn) |=> (perActive == $past(perWrData))); // R8

  for (genvar ch = 0; ch < NUM_DUTY; ch++) begin : g_chk
    AST_IMM_DUTY_LOAD: assert property (@(posedge clk) disable iff (!rstN)
      (immUpdate && dutyWrEn[ch]) |=> (dutyActive[ch] == $past(dutyWrData[ch]))); // R4
  end

endmodule

// File: tb/pwm_update_lockout_bench.sv
module pwm_update_lockout_bench;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned ND = 3;
  localparam int unsigned W  = 16;
  localparam int unsigned WATCHDOG = 5000;

  typedef struct packed {
    logic [2:0]   we;
    logic         pwe;
    logic         lock;
    logic         imm;
    logic         bnd;
    logic [15:0]  data;
    logic [15:0]  e0;
    logic [15:0]  e1;
    logic [15:0]  e2;
    logic [15:0]  ep;
    logic [7:0]   req;
  } vec_t;

  // Channel i is written with data+i, the period with data+0x100.
  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{3'b111, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0010, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 8'd6}, // R6
    '{3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0000, 16'h0010, 16'h0011, 16'h0012, 16'h0110, 8'd3}, // R3
    '{3'b111, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0020, 16'h0010, 16'h0011, 16'h0012, 16'h0110, 8'd2}, // R2
    '{3'b000, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0000, 16'h0010, 16'h0011, 16'h0012, 16'h0110, 8'd2}, // R2
    '{3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0010, 16'h0011, 16'h0012, 16'h0110, 8'd7}, // R7
    '{3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0000, 16'h0020, 16'h0021, 16'h0022, 16'h0120, 8'd7}, // R7
    '{3'b010, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0030, 16'h0020, 16'h0031, 16'h0022, 16'h0120, 8'd4}, // R4
    '{3'b000, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0040, 16'h0020, 16'h0031, 16'h0022, 16'h0120, 8'd5}, // R5
    '{3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0000, 16'h0020, 16'h0031, 16'h0022, 16'h0140, 8'd9}, // R9
    '{3'b001, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0050, 16'h0050, 16'h0031, 16'h0022, 16'h0140, 8'd8}, // R8
    '{3'b100, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0060, 16'h0050, 16'h0031, 16'h0062, 16'h0140, 8'd4}, // R4
    '{3'b011, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0070, 16'h0070, 16'h0071, 16'h0062, 16'h0140, 8'd5}, // R5
    '{3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0000, 16'h0070, 16'h0071, 16'h0062, 16'h0170, 8'd9}  // R9
  };

  logic                    clk = 1'b0;
  logic                    rstN = 1'b0;
  logic [ND-1:0]           dutyWrEn = '0;
  logic [ND-1:0][W-1:0]    dutyWrData = '0;
  logic                    perWrEn = 1'b0;
  logic [W-1:0]            perWrData = '0;
  logic                    lockout = 1'b0;
  logic                    immUpdate = 1'b0;
  logic                    boundary = 1'b0;
  logic [ND-1:0][W-1:0]    dutyActive;
  logic [W-1:0]            perActive;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  pwm_update_lockout #(.NUM_DUTY(ND), .DUTY_W(W), .PER_W(W)) u_pwm_update_lockout (
    .clk        (clk),
    .rstN       (rstN),
    .dutyWrEn   (dutyWrEn),
    .dutyWrData (dutyWrData),
    .perWrEn    (perWrEn),
    .perWrData  (perWrData),
    .lockout    (lockout),
    .immUpdate  (immUpdate),
    .boundary   (boundary),
    .dutyActive (dutyActive),
    .perActive  (perActive)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      failures = failures + 1;
      $display("FAIL watchdog: actual cycles=%0d expected below %0d", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic checkVal(input string tag, input string what,
                          input logic [W-1:0] act, input logic [W-1:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(input string tag, input logic [W-1:0] e0, input logic [W-1:0] e1,
                          input logic [W-1:0] e2, input logic [W-1:0] ep);
    checkVal(tag, "duty0", dutyActive[0], e0);
    checkVal(tag, "duty1", dutyActive[1], e1);
    checkVal(tag, "duty2", dutyActive[2], e2);
    checkVal(tag, "period", perActive, ep);
  endtask

  task automatic idleInputs();
    dutyWrEn = '0; perWrEn = 1'b0; lockout = 1'b0; immUpdate = 1'b0; boundary = 1'b0;
  endtask

  task automatic stepEdge();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkAll("R1", 16'h0, 16'h0, 16'h0, 16'h0);   // R1 during reset
    rstN = 1'b1;
    stepEdge();
    checkAll("R1", 16'h0, 16'h0, 16'h0, 16'h0);   // R1 after release

    for (int v = 0; v < NV; v++) begin
      dutyWrEn  = VECS[v].we;
      for (int c = 0; c < ND; c++) dutyWrData[c] = VECS[v].data + 16'(c);
      perWrEn   = VECS[v].pwe;
      perWrData = VECS[v].data + 16'h0100;
      lockout   = VECS[v].lock;
      immUpdate = VECS[v].imm;
      boundary  = VECS[v].bnd;
      stepEdge();
      checkAll($sformatf("R%0d vec%0d", VECS[v].req, v),
               VECS[v].e0, VECS[v].e1, VECS[v].e2, VECS[v].ep);
    end
    idleInputs();

    // R1: buffers written under lockout, then reset, then transfer loads zeros.
    dutyWrEn = 3'b111; perWrEn = 1'b1; lockout = 1'b1;
    for (int c = 0; c < ND; c++) dutyWrData[c] = 16'h0080 + 16'(c);
    perWrData = 16'h0180;
    stepEdge();
    idleInputs();
    rstN = 1'b0;
    #1;
    checkAll("R1", 16'h0, 16'h0, 16'h0, 16'h0);
    @(negedge clk);
    rstN = 1'b1;
    boundary = 1'b1;
    stepEdge();
    idleInputs();
    checkAll("R1", 16'h0, 16'h0, 16'h0, 16'h0);

    // R5: repeated immediate period writes without boundary never show.
    perWrEn = 1'b1; immUpdate = 1'b1; perWrData = 16'h0abc;
    stepEdge();
    perWrData = 16'h0abd;
    stepEdge();
    idleInputs();
    checkVal("R5", "period", perActive, 16'h0000);
    boundary = 1'b1;
    stepEdge();
    idleInputs();
    checkVal("R3", "period", perActive, 16'h0abd);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule